// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Mode-Fault Detection

This block is an 8-bit SPI port for a system bus. Software writes a control word that sets enable, interrupt enable, bit order, role, clock polarity, clock phase and a master clock rate. As master, the block makes SCK from the system clock and exchanges one byte: it drives MOSI and captures MISO. As slave, it follows an external SCK while an active-low select input is low. The external pins pass through a synchronizer before use.

A completion flag marks the end of every byte. The flag is also set when a mode fault occurs. A mode fault happens when another device pulls select low while this block is master. In that case the block drops back to slave, and software must set the master bit again. An interrupt request combines the flag, the local interrupt enable and a global enable input. The flag clears in two ways: software reads the status register and then accesses the data register, or the interrupt is acknowledged.

Top module: `sbx_spi_unit`

## Requirements
- R1: Bus addresses are 0 for control, 1 for status and 2 for data. Control bits are en[0], irq_en[1], lsb_first[2], master[3], cpol[4], cpha[5] and rate[7:6]. Status bit 7 is the completion flag. After reset, control and status read 0, irq_o is 0 and sck_o is low.
- R2: While en is 0, a data write in master mode leaves sck_o at its idle level and does not set the flag. SCK edges on a selected slave also do not set the flag.
- R3: With lsb_first at 1, bit 0 is shifted first on the output and is received into bit 0 first. With lsb_first at 0, bit 7 comes first in both directions.
- R4: cpol sets the idle level of SCK. With cpha at 0, data is sampled on the edge that leaves idle and changed on the edge that returns to idle. With cpha at 1, this is reversed. All four modes transfer correctly as master.
- R5: In master mode, rate codes 0, 1, 2 and 3 give an SCK period of 4, 16, 64 and 128 system clocks.
- R6: A data write while master, enabled and idle starts an 8-bit exchange. At its end, the received byte reads from address 2 and the flag is set.
- R7: When enabled as slave with select low, the block exchanges a byte on the external SCK in all four modes and both orders. The byte written beforehand is shifted out, the received byte reads back, and the flag is set.
- R8: Raising select part-way through a slave byte aborts the byte without setting the flag. The next full byte is received correctly.
- R9: With select configured as an input, pulling it low while enabled as master clears the master bit and sets the flag. Writing the master bit again restores master mode. With select not configured as an input, pulling it low has no effect.
- R10: irq_o is high only when irq_en, the flag and gie_i are all high.
- R11: The flag clears on a data register access that follows a status read that saw it set. A data access with no such status read first leaves the flag set.
- R12: A pulse on irq_ack_i clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for read side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request |
| ss_is_input_i | input | 1 | Select pin is configured as an input |
| ss_n_i | input | 1 | Active-low select |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock generated in master mode |
| mosi_i | input | 1 | Serial data in, slave role |
| mosi_o | output | 1 | Serial data out, master role |
| miso_i | input | 1 | Serial data in, master role |
| miso_o | output | 1 | Serial data out, slave role |

## Verification
The checks assume the following about the inputs:
- Slave SCK, select and MOSI change slowly compared with the system clock, so that each level lasts longer than the synchronizer delay.
- Master MISO is stable when the generated sampling edge occurs.
- Control bits do not change while a byte is in flight.

The bench meets these assumptions as follows:
- It drives slave pins on the falling system-clock edge with a half period of twelve clocks.
- Its master-side model changes MISO only on the generated edges that are not sampling edges.
- It writes the control word only between transfers.

// File: rtl/sbx_spi_pkg.sv
`timescale 1ns/1ps
package sbx_spi_pkg;

   localparam int REG_W = 8;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;

   typedef struct packed {
      logic [1:0] rate;
      logic       cpha;
      logic       cpol;
      logic       mstr;
      logic       lsb;
      logic       ie;
      logic       en;
   } spi_ctrl_t;

endpackage

// File: rtl/sbx_spi_sync.sv
`timescale 1ns/1ps
module sbx_spi_sync #(
   parameter int             W      = 1,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sbx_spi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/sbx_spi_rate.sv
`timescale 1ns/1ps
module sbx_spi_rate #(
   parameter int DIV0 = 4,
   parameter int DIV1 = 16,
   parameter int DIV2 = 64,
   parameter int DIV3 = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);

   localparam int M01  = (DIV0 > DIV1) ? DIV0 : DIV1;
   localparam int M23  = (DIV2 > DIV3) ? DIV2 : DIV3;
   localparam int DMAX = (M01 > M23) ? M01 : M23;
   localparam int CW   = (DMAX > 2) ? $clog2(DMAX) : 1;

   if ((DIV0 < 2) || (DIV1 < 2) || (DIV2 < 2) || (DIV3 < 2) ||
       (DIV0 % 2 != 0) || (DIV1 % 2 != 0) || (DIV2 % 2 != 0) || (DIV3 % 2 != 0)) begin : g_bad_div
      $error("sbx_spi_rate: divisors must be even and at least 2");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      unique case (sel)
         2'd0:    lim = CW'(DIV0 / 2 - 1);
         2'd1:    lim = CW'(DIV1 / 2 - 1);
         2'd2:    lim = CW'(DIV2 / 2 - 1);
         default: lim = CW'(DIV3 / 2 - 1);
      endcase
   end

   // one tick per half SCK period; >= keeps it safe if sel moves mid-count
   assign tick = run && (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || tick)     cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/sbx_spi_engine.sv
`timescale 1ns/1ps
module sbx_spi_engine #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              mstr,
   input  logic              lsb,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              tick,
   input  logic              abort,
   input  logic              s_sck,
   input  logic              s_ss_n,
   input  logic              s_mosi,
   input  logic              miso_i,
   output logic              m_run,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx,
   output logic              sck_o,
   output logic              out_bit
);

   if (DATA_W < 2) begin : g_bad_w
      $error("sbx_spi_engine: DATA_W must be at least 2");
   end

   localparam int EDGES = 2 * DATA_W;
   localparam int EW    = $clog2(EDGES);

   logic [EW-1:0]     ecnt;
   logic              m_busy;
   logic              sck_lvl;
   logic              sck_prev;
   logic              done_q;
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;

   logic slv_edge, ev, leading, smp, shf, last, kill, start, din;

   assign slv_edge = en && !mstr && !s_ss_n && (s_sck != sck_prev);
   assign ev       = mstr ? (m_busy && tick) : slv_edge;
   assign leading  = ~ecnt[0];
   assign smp      = leading ^ cpha;
   assign shf      = !smp && (ecnt != '0);
   assign last     = (ecnt == EW'(EDGES - 1));
   assign busy     = m_busy || (ecnt != '0);
   assign kill     = !en || abort || (!mstr && s_ss_n);
   assign start    = load && en && mstr && !busy;
   assign din      = mstr ? miso_i : s_mosi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt     <= '0;
         m_busy   <= 1'b0;
         sck_lvl  <= 1'b0;
         sck_prev <= 1'b0;
         done_q   <= 1'b0;
         tx_q     <= '0;
         rx_q     <= '0;
      end else begin
         sck_prev <= s_sck;
         done_q   <= 1'b0;
         if (load && !busy) tx_q <= load_val;
         if (kill) begin
            ecnt    <= '0;
            m_busy  <= 1'b0;
            sck_lvl <= 1'b0;
         end else begin
            if (start) m_busy <= 1'b1;
            if (ev) begin
               ecnt <= last ? '0 : ecnt + 1'b1;
               if (mstr) sck_lvl <= ~sck_lvl;
               if (smp)
                  rx_q <= lsb ? {din, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], din};
               if (shf)
                  tx_q <= lsb ? {1'b0, tx_q[DATA_W-1:1]} : {tx_q[DATA_W-2:0], 1'b0};
               if (last) begin
                  done_q <= 1'b1;
                  m_busy <= 1'b0;
               end
            end
         end
      end
   end

   assign m_run   = m_busy;
   assign done    = done_q;
   assign rx      = rx_q;
   assign sck_o   = (en && mstr) ? (cpol ^ sck_lvl) : cpol;
   assign out_bit = lsb ? tx_q[0] : tx_q[DATA_W-1];

   // R4: generated clock rests at its idle level between master bytes
   p_idle_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !m_busy |-> (sck_o == cpol));

   // R2: disabling the block leaves nothing in flight
   p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);

   // R8: a deselected slave holds its edge count at zero
   p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mstr && s_ss_n) |=> (ecnt == '0));

   // R6: completion is a single-cycle event
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/sbx_spi_regs.sv
`timescale 1ns/1ps
module sbx_spi_regs
   import sbx_spi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [1:0]       addr,
   input  logic [REG_W-1:0] wdata,
   input  logic             done,
   input  logic [REG_W-1:0] rx,
   input  logic             fault_req,
   input  logic             ack,
   output spi_ctrl_t        ctrl,
   output logic [REG_W-1:0] rdata,
   output logic             flag,
   output logic             fault,
   output logic             data_wr
);

   logic [REG_W-1:0] rbuf;
   logic             armed;
   logic             data_acc;
   logic             clr;

   assign fault    = fault_req && ctrl.en && ctrl.mstr;
   assign data_acc = (wr || rd) && (addr == A_DATA);
   assign data_wr  = wr && (addr == A_DATA);
   assign clr      = ack || (armed && data_acc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl  <= '0;
         rbuf  <= '0;
         flag  <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (wr && (addr == A_CTRL)) ctrl <= spi_ctrl_t'(wdata);
         if (fault)                  ctrl.mstr <= 1'b0;
         if (done)                   rbuf <= rx;
         if (done || fault)          flag <= 1'b1;
         else if (clr)               flag <= 1'b0;
         if (clr)                                       armed <= 1'b0;
         else if (rd && (addr == A_STAT) && flag)       armed <= 1'b1;
      end
   end

   always_comb begin
      unique case (addr)
         A_CTRL:  rdata = ctrl;
         A_STAT:  rdata = {flag, {(REG_W-1){1'b0}}};
         A_DATA:  rdata = rbuf;
         default: rdata = '0;
      endcase
   end

   // R9: a fault drops master mode and raises the flag
   p_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!ctrl.mstr && flag));

   // R6: the flag only rises from a completed byte or a fault
   p_flag_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(done || fault));

   // R12: acknowledge clears the flag
   p_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !done && !fault) |=> !flag);

   // R11: a data access without a prior status read keeps the flag
   p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !armed && data_acc && !ack) |=> flag);

endmodule

// File: rtl/sbx_spi_unit.sv
`timescale 1ns/1ps
module sbx_spi_unit
   import sbx_spi_pkg::*;
#(
   parameter int DIV0        = 4,
   parameter int DIV1        = 16,
   parameter int DIV2        = 64,
   parameter int DIV3        = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   input  logic             gie_i,
   input  logic             irq_ack_i,
   output logic             irq_o,
   input  logic             ss_is_input_i,
   input  logic             ss_n_i,
   input  logic             sck_i,
   output logic             sck_o,
   input  logic             mosi_i,
   output logic             mosi_o,
   input  logic             miso_i,
   output logic             miso_o
);

   spi_ctrl_t        ctrl;
   logic             s_sck, s_ss_n, s_mosi;
   logic             flag, fault, data_wr, done, tick, m_run, busy, out_bit;
   logic [REG_W-1:0] rx;

   sbx_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mosi_i, ss_n_i, sck_i}),
      .q     ({s_mosi, s_ss_n, s_sck})
   );

   sbx_spi_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (bus_wr),
      .rd        (bus_rd),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .done      (done),
      .rx        (rx),
      .fault_req (ss_is_input_i && !s_ss_n),
      .ack       (irq_ack_i),
      .ctrl      (ctrl),
      .rdata     (bus_rdata),
      .flag      (flag),
      .fault     (fault),
      .data_wr   (data_wr)
   );

   sbx_spi_rate #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (m_run),
      .sel   (ctrl.rate),
      .tick  (tick)
   );

   sbx_spi_engine #(.DATA_W(REG_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl.en),
      .mstr     (ctrl.mstr),
      .lsb      (ctrl.lsb),
      .cpol     (ctrl.cpol),
      .cpha     (ctrl.cpha),
      .load     (data_wr),
      .load_val (bus_wdata),
      .tick     (tick),
      .abort    (fault),
      .s_sck    (s_sck),
      .s_ss_n   (s_ss_n),
      .s_mosi   (s_mosi),
      .miso_i   (miso_i),
      .m_run    (m_run),
      .busy     (busy),
      .done     (done),
      .rx       (rx),
      .sck_o    (sck_o),
      .out_bit  (out_bit)
   );

   assign mosi_o = out_bit;
   assign miso_o = out_bit;
   assign irq_o  = ctrl.ie && flag && gie_i;

   // R10: a request is never raised while globally masked
   p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |-> !irq_o);

   // R2: a disabled block never leaves the clock idle level
   p_off_sck_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.en && !busy) |-> (sck_o == ctrl.cpol));

endmodule

// File: tb/sim_sbx_spi_unit.sv
`timescale 1ns/1ps
module sim_sbx_spi_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       gie_i = 1'b0, irq_ack_i = 1'b0, irq_o;
   logic       ss_is_input_i = 1'b0, ss_n_i = 1'b1, sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0;
   logic       sck_o, mosi_o, miso_o;

   int checks = 0, failures = 0, cyc = 0, sck_tog = 0;

   // master-side model state
   bit         mdl_on = 1'b0;
   int         mdl_e = 0, mdl_cpol = 0, mdl_cpha = 0, mdl_lsb = 0;
   logic [7:0] mdl_mi = 8'd0, mdl_cap = 8'd0;
   int         t0 = 0, t2 = 0;

   sbx_spi_unit u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie_i(gie_i), .irq_ack_i(irq_ack_i),
      .irq_o(irq_o), .ss_is_input_i(ss_is_input_i), .ss_n_i(ss_n_i), .sck_i(sck_i),
      .sck_o(sck_o), .mosi_i(mosi_i), .mosi_o(mosi_o), .miso_i(miso_i), .miso_o(miso_o)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int pos(int i, int lsb);
      return lsb ? i : 7 - i;
   endfunction

   function automatic logic [7:0] cw(int rate, int cpha, int cpol, int mstr, int lsb, int ie, int en);
      return {rate[1:0], cpha[0], cpol[0], mstr[0], lsb[0], ie[0], en[0]};
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [1:0] a, logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [1:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // model of the far device on the master bus
   always @(sck_o) begin
      sck_tog++;
      if (mdl_on) begin
         if (mdl_e == 0) t0 = cyc;
         if (mdl_e == 2) t2 = cyc;
         if (((mdl_e % 2) == 0) == (mdl_cpha == 0)) begin
            mdl_cap[pos(mdl_e / 2, mdl_lsb)] = mosi_o;
         end else if (mdl_cpha == 0) begin
            if ((mdl_e + 1) / 2 < 8) miso_i = mdl_mi[pos((mdl_e + 1) / 2, mdl_lsb)];
         end else begin
            miso_i = mdl_mi[pos(mdl_e / 2, mdl_lsb)];
         end
         mdl_e++;
      end
   end

   task automatic m_xfer(int rate, int cpol, int cpha, int lsb, logic [7:0] txb, logic [7:0] mib);
      logic [7:0] v;
      int n;
      int dv;
      bus_write(2'd0, cw(rate, cpha, cpol, 1, lsb, 0, 1));
      mdl_cpol = cpol; mdl_cpha = cpha; mdl_lsb = lsb; mdl_mi = mib;
      mdl_e = 0; mdl_cap = 8'd0;
      miso_i = (cpha == 0) ? mib[pos(0, lsb)] : 1'b0;
      mdl_on = 1'b1;
      bus_write(2'd2, txb);
      n = 0;
      do begin bus_read(2'd1, v); n++; end while (!v[7] && n < 4000);
      chk("R6 flag after master byte", int'(v[7]), 1);
      chk("R4 sck back at idle", int'(sck_o), cpol);
      bus_read(2'd2, v);
      chk($sformatf("R6 R4 received cpol%0d cpha%0d lsb%0d", cpol, cpha, lsb), v, mib);
      chk($sformatf("R3 R4 shifted out cpol%0d cpha%0d lsb%0d", cpol, cpha, lsb), mdl_cap, txb);
      dv = (rate < 3) ? (4 << (2 * rate)) : 128;
      chk($sformatf("R5 sck period rate%0d", rate), t2 - t0, dv);
      mdl_on = 1'b0;
      bus_read(2'd1, v);
      chk("R11 flag cleared by status then data", int'(v[7]), 0);
   endtask

   task automatic s_xfer(int cpol, int cpha, int lsb, logic [7:0] txb, logic [7:0] mob,
                         int stop_at, output logic [7:0] cap);
      cap = 8'd0;
      bus_write(2'd0, cw(0, cpha, cpol, 0, lsb, 0, 1));
      sck_i = cpol[0];
      bus_write(2'd2, txb);
      if (cpha == 0) mosi_i = mob[pos(0, lsb)];
      idle(4);
      ss_n_i = 1'b0;
      idle(12);
      for (int e = 0; e < 16; e++) begin
         if (stop_at != 0 && e == stop_at) break;
         sck_i = ~sck_i;
         if (((e % 2) == 0) == (cpha == 0)) cap[pos(e / 2, lsb)] = miso_o;
         else if (cpha == 0) begin
            if ((e + 1) / 2 < 8) mosi_i = mob[pos((e + 1) / 2, lsb)];
         end else mosi_i = mob[pos(e / 2, lsb)];
         idle(12);
      end
      ss_n_i = 1'b1;
      idle(4);
      sck_i = cpol[0];
      idle(4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] v, cap;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      bus_read(2'd0, v); chk("R1 control after reset", v, 0);
      bus_read(2'd1, v); chk("R1 status after reset", v, 0);
      chk("R1 irq after reset", int'(irq_o), 0);
      chk("R1 sck after reset", int'(sck_o), 0);

      // R2 disabled master and slave
      bus_write(2'd0, cw(0, 0, 1, 1, 0, 0, 0));
      idle(2); sck_tog = 0;
      bus_write(2'd2, 8'h5A);
      idle(300);
      chk("R2 no sck edges while off", sck_tog, 0);
      bus_read(2'd1, v); chk("R2 no flag while off master", int'(v[7]), 0);
      bus_write(2'd0, cw(0, 0, 0, 0, 0, 0, 0));
      ss_n_i = 1'b0; idle(4);
      for (int e = 0; e < 16; e++) begin sck_i = ~sck_i; idle(12); end
      ss_n_i = 1'b1; idle(6);
      bus_read(2'd1, v); chk("R2 no flag while off slave", int'(v[7]), 0);

      // R3 R4 R5 R6 master sweep
      for (int m = 0; m < 4; m++)
         for (int l = 0; l < 2; l++)
            for (int k = 0; k < 2; k++)
               m_xfer(0, m / 2, m % 2, l, 8'hA5 ^ 8'(37 * (m * 4 + l * 2 + k)),
                      8'h3C + 8'(91 * (m * 4 + l * 2 + k)));
      for (int r = 1; r < 4; r++) m_xfer(r, r % 2, 0, 0, 8'h96 + 8'(r), 8'h1E ^ 8'(r * 17));

      // R7 slave sweep
      for (int m = 0; m < 4; m++)
         for (int l = 0; l < 2; l++) begin
            logic [7:0] tb_tx, tb_mo;
            tb_tx = 8'hC3 ^ 8'(29 * (m * 2 + l));
            tb_mo = 8'h71 + 8'(53 * (m * 2 + l));
            s_xfer(m / 2, m % 2, l, tb_tx, tb_mo, 0, cap);
            bus_read(2'd1, v); chk("R7 slave flag", int'(v[7]), 1);
            bus_read(2'd2, v);
            chk($sformatf("R7 slave received mode%0d lsb%0d", m, l), v, tb_mo);
            chk($sformatf("R7 slave shifted out mode%0d lsb%0d", m, l), cap, tb_tx);
         end

      // R8 abort part-way, then a full byte
      s_xfer(0, 0, 0, 8'hE7, 8'h42, 5, cap);
      bus_read(2'd1, v); chk("R8 no flag after abort", int'(v[7]), 0);
      s_xfer(0, 0, 0, 8'h18, 8'hB9, 0, cap);
      bus_read(2'd1, v); chk("R8 flag after full byte", int'(v[7]), 1);
      bus_read(2'd2, v); chk("R8 byte after abort", v, 8'hB9);
      chk("R8 shifted out after abort", cap, 8'h18);

      // R9 select low with select not an input: no fault
      ss_is_input_i = 1'b0;
      bus_write(2'd0, cw(0, 0, 0, 1, 0, 1, 1));
      ss_n_i = 1'b0; idle(6);
      bus_read(2'd0, v); chk("R9 no fault when select is output", int'(v[3]), 1);
      bus_read(2'd1, v); chk("R9 no flag when select is output", int'(v[7]), 0);
      ss_n_i = 1'b1; idle(4);

      // R9 fault, R10 irq gating
      ss_is_input_i = 1'b1;
      ss_n_i = 1'b0; idle(6);
      bus_read(2'd0, v); chk("R9 master bit cleared", v, cw(0, 0, 0, 0, 0, 1, 1));
      chk("R10 irq masked by global enable", int'(irq_o), 0);
      gie_i = 1'b1; idle(1);
      chk("R10 irq with all three high", int'(irq_o), 1);
      bus_write(2'd0, cw(0, 0, 0, 0, 0, 0, 1));
      chk("R10 irq masked by local enable", int'(irq_o), 0);
      bus_write(2'd0, cw(0, 0, 0, 0, 0, 1, 1));
      bus_read(2'd1, v); chk("R9 flag set by fault", int'(v[7]), 1);

      // R12 acknowledge
      @(negedge clk); irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
      chk("R12 irq dropped after ack", int'(irq_o), 0);
      bus_read(2'd1, v); chk("R12 flag cleared by ack", int'(v[7]), 0);
      ss_n_i = 1'b1; idle(4);
      bus_write(2'd0, cw(0, 0, 0, 1, 0, 0, 1));
      bus_read(2'd0, v); chk("R9 master restored by write", int'(v[3]), 1);
      gie_i = 1'b0;

      // R11 data access without status read keeps the flag
      mdl_cpol = 0; mdl_cpha = 0; mdl_lsb = 0; mdl_mi = 8'h00; mdl_e = 0; mdl_on = 1'b1;
      bus_write(2'd2, 8'h66);
      idle(60);
      mdl_on = 1'b0;
      bus_read(2'd2, v);
      bus_read(2'd1, v); chk("R11 flag kept without status read", int'(v[7]), 1);
      bus_read(2'd2, v);
      bus_read(2'd1, v); chk("R11 flag cleared after status read", int'(v[7]), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule